// File: doc/BRIEF.md
# Flash Status Register with Sticky Error Flags

This block keeps the 8-bit status word of a flash device. An internal program/erase sequencer reports to it: it drives the ready/busy state and two suspend indications as levels, and it raises one-cycle error pulses. Error flags are sticky. They collect every error seen over a series of operations, and they drop only on an explicit clear-command strobe or on device reset. Software can therefore run a batch of programs or erases and look for a failure once at the end.

The host reads the status over a 16-bit bus. Chip-enable and output-enable are active low and are sampled on the block clock. A read is active while both are low. The block captures the status word on the first clock edge of an active read, which is the edge after whichever enable fell last. It holds that copy until the read ends. A host that polls for completion must therefore toggle an enable to see a newer value. The status sits on the low byte and the high byte reads zero.

Top module: `flash_stat_reg`

## Requirements
- R1: While reset is asserted, and after its release until the first capture, rd_data reads 0x0000 and rd_drv is 0. Reset clears every status bit.
- R2: Status bit 7 is the ready flag. One cycle after seq_busy is sampled, bit 7 holds its inverse (1 = ready, 0 = busy).
- R3: Bit 6 (erase suspended) and bit 2 (program suspended) follow seq_ers_susp and seq_pgm_susp with one cycle of delay. The sequencer can clear them by dropping the input.
- R4: A pulse on seq_err sets a sticky flag. seq_err[0] maps to bit 1 (locked-block abort), [1] to bit 3 (supply fault), [2] to bit 4 (program fail) and [3] to bit 5 (erase fail). The flag stays set after the pulse ends.
- R5: Error pulses from separate operations accumulate by OR into the sticky flags.
- R6: A clr_cmd pulse zeroes bits 1, 3, 4 and 5 and leaves bits 7, 6 and 2 as they are.
- R7: When clr_cmd and a seq_err pulse arrive in the same cycle, the clear acts first and the new error is kept.
- R8: rd_data[15:8] always reads 0x00 and status bit 0 always reads 0.
- R9: The status word shown on rd_data is captured on the first clock edge of an active read. It stays unchanged for the whole read even when the status changes.
- R10: A fresh value appears only after one enable rises and falls again, whichever enable falls last. The new capture holds every update made before it.
- R11: rd_drv is 1 from the first clock edge of an active read until the clock edge after either enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_busy | input | 1 | Sequencer busy level |
| seq_ers_susp | input | 1 | Sequencer erase-suspended level |
| seq_pgm_susp | input | 1 | Sequencer program-suspended level |
| seq_err | input | 4 | One-cycle error pulses, mapping given in R4 |
| clr_cmd | input | 1 | One-cycle decoded clear-status command |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 16 | Captured status on bits 7:0, zero above |
| rd_drv | output | 1 | High while a captured status read is being presented |

## Verification
The bench sends a clear and an error pulse in the same cycle. A design that gave the clear priority would lose the error and read back without that flag. It clears while the suspend and busy levels are active, which catches a clear that wipes the whole register instead of only the sticky flags. During a held read it changes the busy level and injects an error, which exposes a read path that tracks the live register. It then ends the read by raising only one enable and restarts it by lowering that same enable. A design that only reacts to one of the strobes would show a stale word or no capture at all.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W   = 8;
  localparam int ERR_N  = 4;
  localparam int B_RDY  = 7;
  localparam int B_ESUS = 6;
  localparam int B_PSUS = 2;
  // status bit that each sticky error input lands on
  localparam int ERR_POS [ERR_N] = '{1, 3, 4, 5};
endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic en;
    logic d;

    // a set in the clear cycle wins: clear first, then record
    always_comb begin
      en = clr_i | set_i[g];
      d  = set_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  flag_q[g] <= 1'b0;
      else if (en)  flag_q[g] <= d;
    end

    p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i) |=> flag_q[g]);
    p_setwin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fsr_live.sv
module fsr_live (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic esus_i,
  input  logic psus_i,
  output logic rdy_o,
  output logic esus_o,
  output logic psus_o
);
  logic [2:0] lv_q;
  logic [2:0] lv_d;

  always_comb begin
    lv_d = {~busy_i, esus_i, psus_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lv_q <= '0;
    else         lv_q <= lv_d;
  end

  assign rdy_o  = lv_q[2];
  assign esus_o = lv_q[1];
  assign psus_o = lv_q[0];

  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !rdy_o);
  p_susp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !esus_i |=> !esus_o);
endmodule

// File: rtl/fsr_snap.sv
module fsr_snap #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] snap_o,
  output logic         act_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;
  logic         act_q;
  logic         cap;

  always_comb begin
    cap    = act_i & ~act_q;
    snap_d = cap ? stat_i : snap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      act_q  <= 1'b0;
    end else begin
      act_q <= act_i;
      if (cap) snap_q <= snap_d;
    end
  end

  assign snap_o = snap_q;
  assign act_o  = act_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && act_q) |=> $stable(snap_q));
  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !act_q) |=> (snap_q == $past(stat_i)));
endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
  import fsr_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_busy,
  input  logic             seq_ers_susp,
  input  logic             seq_pgm_susp,
  input  logic [ERR_N-1:0] seq_err,
  input  logic             clr_cmd,
  input  logic             ce_n,
  input  logic             oe_n,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_drv
);
  localparam int PAD_W = BUS_W - SR_W;

  logic             rst_sn;
  logic [ERR_N-1:0] err_flags;
  logic             rdy, esus, psus;
  logic [SR_W-1:0]  stat_live;
  logic [SR_W-1:0]  stat_snap;
  logic             rd_act;

  fsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk), .arst_ni(rst_n), .rst_no(rst_sn)
  );

  fsr_sticky #(.N(ERR_N)) u_sticky (
    .clk_i(clk), .rst_ni(rst_sn), .clr_i(clr_cmd),
    .set_i(seq_err), .flag_o(err_flags)
  );

  fsr_live u_live (
    .clk_i(clk), .rst_ni(rst_sn), .busy_i(seq_busy),
    .esus_i(seq_ers_susp), .psus_i(seq_pgm_susp),
    .rdy_o(rdy), .esus_o(esus), .psus_o(psus)
  );

  always_comb begin
    stat_live         = '0;
    stat_live[B_RDY]  = rdy;
    stat_live[B_ESUS] = esus;
    stat_live[B_PSUS] = psus;
    for (int k = 0; k < ERR_N; k++) begin
      stat_live[ERR_POS[k]] = err_flags[k];
    end
  end

  assign rd_act = ~ce_n & ~oe_n;

  fsr_snap #(.W(SR_W)) u_snap (
    .clk_i(clk), .rst_ni(rst_sn), .act_i(rd_act),
    .stat_i(stat_live), .snap_o(stat_snap), .act_o(rd_drv)
  );

  assign rd_data = {{PAD_W{1'b0}}, stat_snap};

  p_pad_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_drv |-> (rd_data[BUS_W-1:SR_W] == '0 && !rd_data[0]));
  p_drv_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (ce_n || oe_n) |=> !rd_drv);
endmodule

// File: tb/flash_stat_reg_tb_top.sv
`timescale 1ns/1ps
module flash_stat_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seq_busy, seq_ers_susp, seq_pgm_susp, clr_cmd, ce_n, oe_n;
  logic [3:0]  seq_err;
  logic [15:0] rd_data;
  logic        rd_drv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bench-side model of the live status word
  logic       m_busy = 1'b0, m_esus = 1'b0, m_psus = 1'b0;
  logic [3:0] m_err = 4'h0;

  always #2 clk = ~clk;

  flash_stat_reg dut_i (
    .clk(clk), .rst_n(rst_n), .seq_busy(seq_busy), .seq_ers_susp(seq_ers_susp),
    .seq_pgm_susp(seq_pgm_susp), .seq_err(seq_err), .clr_cmd(clr_cmd),
    .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data), .rd_drv(rd_drv)
  );

  function automatic logic [15:0] exp_sr();
    return {8'h00, ~m_busy, m_esus, m_err[3], m_err[2], m_err[1], m_psus, m_err[0], 1'b0};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_lvl(logic b, logic e, logic p);
    seq_busy = b; seq_ers_susp = e; seq_pgm_susp = p;
    m_busy = b; m_esus = e; m_psus = p;
    tick();
  endtask

  task automatic pulse(logic [3:0] err, logic clr);
    seq_err = err; clr_cmd = clr;
    m_err = (clr ? 4'h0 : m_err) | err;
    tick();
    seq_err = 4'h0; clr_cmd = 1'b0;
  endtask

  task automatic rd_begin(string tag);
    ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(exp_sr());
    tag_q.push_back(tag);
    tick();
  endtask

  task automatic rd_end();
    ce_n = 1'b1; oe_n = 1'b1;
    tick();
  endtask

  // monitor: compare each new captured read against the scoreboard
  bit drv_seen = 0;
  always @(negedge clk) begin
    if (rd_drv && !drv_seen) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", {15'h0, rd_drv}, 16'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
    drv_seen = rd_drv;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; seq_busy = 1'b0; seq_ers_susp = 1'b0; seq_pgm_susp = 1'b0;
    seq_err = 4'h0; clr_cmd = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) tick();
    chk("R1 data in reset", rd_data, 16'h0000);
    chk("R1 drv in reset", {15'h0, rd_drv}, 16'h0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 data after release", rd_data, 16'h0000);

    rd_begin("R2 idle ready"); rd_end();
    set_lvl(1'b1, 1'b0, 1'b0);
    rd_begin("R2 busy"); rd_end();
    set_lvl(1'b0, 1'b0, 1'b0);

    set_lvl(1'b0, 1'b1, 1'b0);
    rd_begin("R3 erase susp"); rd_end();
    set_lvl(1'b0, 1'b1, 1'b1);
    rd_begin("R3 both susp"); rd_end();
    set_lvl(1'b0, 1'b0, 1'b0);
    rd_begin("R3 susp cleared by sequencer"); rd_end();

    pulse(4'b0100, 1'b0);
    rd_begin("R4 program fail"); rd_end();
    repeat (5) tick();
    rd_begin("R4 still set"); rd_end();

    pulse(4'b1000, 1'b0);
    rd_begin("R5 add erase fail"); rd_end();
    pulse(4'b0001, 1'b0);
    pulse(4'b0010, 1'b0);
    rd_begin("R5 all accumulated"); rd_end();

    set_lvl(1'b1, 1'b1, 1'b0);
    pulse(4'b0000, 1'b1);
    rd_begin("R6 clear keeps live bits"); rd_end();

    pulse(4'b0010, 1'b0);
    pulse(4'b0100, 1'b1);
    rd_begin("R7 clear with new error"); rd_end();
    set_lvl(1'b0, 1'b0, 1'b0);
    pulse(4'b0000, 1'b1);

    rd_begin("R8 clean word");
    chk("R8 upper byte", {8'h00, rd_data[15:8]}, 16'h0000);
    chk("R8 bit0", {15'h0, rd_data[0]}, 16'h0);
    chk("R11 drv during read", {15'h0, rd_drv}, 16'h1);
    held = rd_data;
    pulse(4'b1000, 1'b0);
    set_lvl(1'b1, 1'b0, 1'b1);
    repeat (3) tick();
    chk("R9 frozen during read", rd_data, held);

    oe_n = 1'b1;
    tick();
    chk("R11 drv after oe rises", {15'h0, rd_drv}, 16'h0);
    chk("R10 no new value while idle", rd_data, held);
    oe_n = 1'b0;
    exp_q.push_back(exp_sr()); tag_q.push_back("R10 oe fell last");
    tick();
    ce_n = 1'b1;
    tick();
    set_lvl(1'b0, 1'b0, 1'b0);
    ce_n = 1'b0;
    exp_q.push_back(exp_sr()); tag_q.push_back("R10 ce fell last");
    tick();
    rd_end();
    chk("R11 drv after end", {15'h0, rd_drv}, 16'h0);
    chk("R10 scoreboard drained", 16'(exp_q.size()), 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule